// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This unit is the arithmetic and logic stage of a small 8-bit microcontroller datapath. Each transaction carries an operation code, two operands (a register value and either a second register or an immediate, already chosen by the decoder), and the current five status flags. The unit returns an 8-bit result, a new flag vector, a per-flag write-enable mask and a result write-enable. The status register, register file and decoder stay outside the unit. The surrounding core writes back only the flags whose mask bit is set, and writes the result only when the result write-enable is high.

The arithmetic and logic are combinational. A single output register gives the one-cycle latency the core expects. Both edges use valid/ready. A transaction is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, every output holds unchanged. `in_ready` equals `!out_valid || out_ready`, so back-pressure passes straight through with no extra storage.

Flag vector bit order, used by `flags_in`, `flags_out` and `flag_we`:

| Bit | Flag |
|-----|------|
| 0 | C (carry or borrow) |
| 1 | Z (zero) |
| 2 | N (negative) |
| 3 | V (signed overflow) |
| 4 | H (half carry) |

Top module: `alu8_core`

## Requirements

In these requirements, `a` is the first operand and `b` is the second.

- R1: ADD (op 0) gives a+b and ADC (op 1) gives a+b+C. Both write all five flags:
  - C is the carry out of bit 7.
  - H is the carry out of bit 3.
  - V is two's-complement overflow.
  - N is result bit 7.
  - Z is set when the result is zero.
- R2: SUB (op 2) gives a-b and SBC (op 3) gives a-b-C. Both write all five flags:
  - C is the borrow out of bit 7.
  - H is the borrow out of bit 3.
  - V is signed overflow of the subtraction.
  - N is result bit 7.
- R3: For SBC (op 3) and CPC (op 5), the new Z is the incoming Z ANDed with "result is zero". A nonzero result clears Z; a zero result keeps the old Z.
- R4: CP (op 4) and CPC (op 5) produce the flags of SUB and SBC, with `res_we` low. All other ops except op 15 drive `res_we` high.
- R5: AND (op 6), OR (op 7) and XOR (op 8) write only Z, N and V (mask 0b01110), with V forced to 0.
- R6: COM (op 9) gives 0xFF-a. It writes C, Z, N and V (mask 0b01111), with C=1 and V=0. H is not written.
- R7: NEG (op 10) gives 0x00-a and writes all five flags:
  - C=1 when a is nonzero.
  - H=1 when a[3:0] is nonzero.
  - V=1 only when a=0x80.
- R8: INC (op 11) gives a+1 and DEC (op 12) gives a-1. Both write only Z, N and V (mask 0b01110). V=1 for INC only when a=0x7F, and for DEC only when a=0x80.
- R9: The constant operations:
  - CLR (op 13) gives 0x00 and writes Z=1, N=0, V=0 (mask 0b01110).
  - SER (op 14) gives 0xFF and writes no flag (mask 0).
- R10: Every `flags_out` bit whose `flag_we` bit is 0 equals the matching `flags_in` bit of the same transaction.
- R11: The result of a transaction accepted on edge k is presented with `out_valid` high after edge k. Under `out_valid && !out_ready` all outputs hold. `in_ready` is high exactly when `!out_valid || out_ready`.
- R12: While `rst_n` is low, `out_valid` is 0.
- R13: Op 15 is reserved. It passes `a` through as the result, with `flag_we`=0 and `res_we`=0.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Transaction present on the input side |
| in_ready | output | 1 | Unit can accept a transaction this cycle |
| op | input | 4 | Operation code (see requirements) |
| a | input | 8 | First operand |
| b | input | 8 | Second operand (register or immediate) |
| flags_in | input | 5 | Current status flags {H,V,N,Z,C} |
| out_valid | output | 1 | Result present on the output side |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res | output | 8 | Result value |
| flags_out | output | 5 | New flag vector {H,V,N,Z,C} |
| flag_we | output | 5 | Per-flag write enable, same bit order |
| res_we | output | 1 | Result should be written back |

## Verification

Every result is due exactly one clock edge after the edge that accepts it. It then stays on the outputs for as long as `out_ready` is held low.

The bench samples and drives inputs at the falling edge. It notes acceptance and consumption from the handshake levels in that half cycle. It keeps a queue of expected outputs built by a behavioural model from the requirements. At each falling edge it compares the visible output against the head of that queue. That includes the stalled cycles, which checks the hold rule.

Corner operands are directed first:
- nibble and byte carry boundaries
- 0x7F and 0x80
- zero results with Z both set and clear on input

Random traffic with random back-pressure follows.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int NFLAG = 5;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CP  = 4'd4,
    OP_CPC = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_XOR = 4'd8,
    OP_COM = 4'd9,
    OP_NEG = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12,
    OP_CLR = 4'd13,
    OP_SER = 4'd14,
    OP_RSV = 4'd15
  } alu_op_e;

  // bit4..bit0 = H V N Z C
  typedef struct packed {
    logic h;
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

  localparam alu_flags_t MASK_ALL  = '{h: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
  localparam alu_flags_t MASK_ZNV  = '{h: 1'b0, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0};
  localparam alu_flags_t MASK_ZNVC = '{h: 1'b0, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
  localparam alu_flags_t MASK_NONE = '0;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         co,
  output logic         hc,
  output logic         ov
);
  localparam int HW = W / 2;

  logic [W:0]  wide;
  logic [HW:0] low;

  always_comb begin
    if (sub) begin
      wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
      low  = {1'b0, x[HW-1:0]} - {1'b0, y[HW-1:0]} - {{HW{1'b0}}, ci};
    end else begin
      wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      low  = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, ci};
    end
    r  = wide[W-1:0];
    co = wide[W];
    hc = low[HW];
    if (sub) ov = (x[W-1] != y[W-1]) && (wide[W-1] != x[W-1]);
    else     ov = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  always_comb begin
    unique case (alu_op_e'(op))
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  r = ~a;
      OP_CLR:  r = '0;
      OP_SER:  r = '1;
      default: r = a;
    endcase
  end
endmodule

// File: rtl/alu8_flagsel.sv
module alu8_flagsel
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  alu_flags_t   fi,
  input  logic [W-1:0] ar,
  input  logic         ac,
  input  logic         ah,
  input  logic         av,
  input  logic [W-1:0] lr,
  output logic [W-1:0] res,
  output alu_flags_t   fo_raw,
  output alu_flags_t   we,
  output logic         rwe
);
  logic arith_sel;

  always_comb begin
    unique case (alu_op_e'(op))
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
      OP_NEG, OP_INC, OP_DEC: arith_sel = 1'b1;
      default:                arith_sel = 1'b0;
    endcase
    res = arith_sel ? ar : lr;

    fo_raw.c = ac;
    fo_raw.h = ah;
    fo_raw.v = arith_sel ? av : 1'b0;
    fo_raw.n = res[W-1];
    fo_raw.z = (res == '0);
    we  = MASK_NONE;
    rwe = 1'b1;

    unique case (alu_op_e'(op))
      OP_ADD, OP_ADC, OP_SUB, OP_NEG: we = MASK_ALL;
      OP_SBC: begin
        we = MASK_ALL;
        fo_raw.z = fi.z & (res == '0);
      end
      OP_CP: begin
        we  = MASK_ALL;
        rwe = 1'b0;
      end
      OP_CPC: begin
        we  = MASK_ALL;
        rwe = 1'b0;
        fo_raw.z = fi.z & (res == '0);
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_CLR: we = MASK_ZNV;
      OP_COM: begin
        we = MASK_ZNVC;
        fo_raw.c = 1'b1;
      end
      OP_SER: we = MASK_NONE;
      default: begin
        we  = MASK_NONE;
        rwe = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [NFLAG-1:0] flags_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     res,
  output logic [NFLAG-1:0] flags_out,
  output logic [NFLAG-1:0] flag_we,
  output logic             res_we
);
  alu_flags_t   fi;
  logic [W-1:0] opx, opy;
  logic         op_ci, op_sub;
  logic [W-1:0] ar, lr, nres;
  logic         ac, ah, av, nrwe;
  alu_flags_t   fo_raw, nwe, nfo;

  assign fi = alu_flags_t'(flags_in);

  // operand steering for the shared adder/subtractor
  always_comb begin
    opx    = a;
    opy    = b;
    op_ci  = 1'b0;
    op_sub = 1'b0;
    unique case (alu_op_e'(op))
      OP_ADC: op_ci = fi.c;
      OP_SUB, OP_CP: op_sub = 1'b1;
      OP_SBC, OP_CPC: begin
        op_sub = 1'b1;
        op_ci  = fi.c;
      end
      OP_NEG: begin
        opx    = '0;
        opy    = a;
        op_sub = 1'b1;
      end
      OP_INC: opy = W'(1);
      OP_DEC: begin
        opy    = W'(1);
        op_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x(opx), .y(opy), .ci(op_ci), .sub(op_sub),
    .r(ar), .co(ac), .hc(ah), .ov(av)
  );

  alu8_bitwise #(.W(W)) u_bitwise (
    .op(op), .a(a), .b(b), .r(lr)
  );

  alu8_flagsel #(.W(W)) u_flagsel (
    .op(op), .fi(fi), .ar(ar), .ac(ac), .ah(ah), .av(av), .lr(lr),
    .res(nres), .fo_raw(fo_raw), .we(nwe), .rwe(nrwe)
  );

  // unwritten flags pass through from the input
  assign nfo = (fo_raw & nwe) | (fi & ~nwe);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      flags_out <= '0;
      flag_we   <= '0;
      res_we    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        res       <= nres;
        flags_out <= nfo;
        flag_we   <= nwe;
        res_we    <= nrwe;
      end
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       op,
  input logic [W-1:0]     a,
  input logic [NFLAG-1:0] flags_in,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     res,
  input logic [NFLAG-1:0] flags_out,
  input logic [NFLAG-1:0] flag_we,
  input logic             res_we
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_accept_shows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res) && $stable(flags_out)
                                   && $stable(flag_we) && $stable(res_we)));

  p_stall_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_CP || op == OP_CPC)) |=> (!res_we && flag_we == 5'b11111));

  p_logic_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_AND || op == OP_OR || op == OP_XOR))
      |=> (flag_we == 5'b01110 && !flags_out[3]));

  p_ser_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_SER) |=> (res == '1 && flag_we == '0 && res_we));

  p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (((flags_out ^ $past(flags_in)) & ~flag_we) == '0));

  p_reserved_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_RSV) |=> (res == $past(a) && flag_we == '0 && !res_we));

  always_comb begin
    if (!rst_n) a_reset_r12: assert (!out_valid);
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op(op), .a(a), .flags_in(flags_in), .out_valid(out_valid),
  .out_ready(out_ready), .res(res), .flags_out(flags_out),
  .flag_we(flag_we), .res_we(res_we)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic [4:0] flags_in = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] res;
  logic [4:0] flags_out, flag_we;
  logic       res_we;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [18:0] exp_q[$];
  logic [3:0]  op_q[$];

  always #10 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .a(a), .b(b), .flags_in(flags_in), .out_valid(out_valid),
    .out_ready(out_ready), .res(res), .flags_out(flags_out),
    .flag_we(flag_we), .res_we(res_we)
  );

  function automatic string tag_of(int o);
    case (o)
      0, 1:   return "R1";
      2:      return "R2";
      3:      return "R2/R3";
      4:      return "R4";
      5:      return "R4/R3";
      6, 7, 8: return "R5";
      9:      return "R6";
      10:     return "R7";
      11, 12: return "R8";
      13, 14: return "R9";
      default: return "R13";
    endcase
  endfunction

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // behavioural model: returns {res[7:0], flags[4:0], mask[4:0], rwe}
  function automatic logic [18:0] model(int o, int x, int y, logic [4:0] fi);
    int r = 0, s = 0, hs = 0, sv = 0;
    int ci = fi[0];
    logic c = 0, z = 0, n = 0, v = 0, h = 0;
    logic [4:0] m = 0, fo;
    logic w = 1;
    case (o)
      0, 1: begin
        if (o == 0) ci = 0;
        s = x + y + ci; hs = (x % 16) + (y % 16) + ci; sv = sgn(x) + sgn(y) + ci;
        r = s % 256; c = s > 255; h = hs > 15; v = (sv > 127) || (sv < -128); m = 5'h1F;
      end
      2, 3, 4, 5: begin
        if (o == 2 || o == 4) ci = 0;
        s = x - y - ci; hs = (x % 16) - (y % 16) - ci; sv = sgn(x) - sgn(y) - ci;
        r = (s + 256) % 256; c = s < 0; h = hs < 0; v = (sv > 127) || (sv < -128); m = 5'h1F;
        w = (o == 2 || o == 3);
      end
      6: begin r = x & y; m = 5'h0E; end
      7: begin r = x | y; m = 5'h0E; end
      8: begin r = x ^ y; m = 5'h0E; end
      9: begin r = 255 - x; c = 1; m = 5'h0F; end
      10: begin r = (256 - x) % 256; c = x != 0; h = (x % 16) != 0; v = x == 128; m = 5'h1F; end
      11: begin r = (x + 1) % 256; v = x == 127; m = 5'h0E; end
      12: begin r = (x + 255) % 256; v = x == 128; m = 5'h0E; end
      13: begin r = 0; m = 5'h0E; end
      14: begin r = 255; m = 0; end
      default: begin r = x; m = 0; w = 0; end
    endcase
    n = r >= 128;
    z = (r == 0);
    if (o == 3 || o == 5) z = z && fi[1];  // R3 sticky zero
    fo = {h, v, n, z, c};
    fo = (fo & m) | (fi & ~m);             // R10 pass-through
    return {r[7:0], fo, m, w};
  endfunction

  // one clock: check visible output, drive new inputs, book-keep handshake
  task automatic cycle(input logic dv, input int o, input int x, input int y,
                       input logic [4:0] fi, input logic rdy, output logic accepted);
    logic [18:0] e;
    @(negedge clk);
    cycles++;
    if (out_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11: out_valid=1 with nothing accepted (actual res=%02h, expected no output)", res);
      end else begin
        e = exp_q[0];
        if ({res, flags_out, flag_we, res_we} !== e) begin
          n_bad++;
          $display("FAIL %s op=%0d: actual res=%02h fl=%05b we=%05b rwe=%0b expected res=%02h fl=%05b we=%05b rwe=%0b",
                   tag_of(op_q[0]), op_q[0], res, flags_out, flag_we, res_we,
                   e[18:11], e[10:6], e[5:1], e[0]);
        end
      end
    end else if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: out_valid actual 0 expected 1 (pending %0d)", exp_q.size());
    end
    in_valid  = dv;
    op        = o[3:0];
    a         = x[7:0];
    b         = y[7:0];
    flags_in  = fi;
    out_ready = rdy;
    #1;
    n_cmp++;  // R11: ready rule
    if (in_ready !== (!out_valid || out_ready)) begin
      n_bad++;
      $display("FAIL R11: in_ready actual %0b expected %0b", in_ready, !out_valid || out_ready);
    end
    if (out_valid && out_ready && exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      void'(op_q.pop_front());
    end
    accepted = dv && in_ready;
    if (accepted) begin
      exp_q.push_back(model(o, x, y, fi));
      op_q.push_back(o[3:0]);
    end
  endtask

  task automatic send(input int o, input int x, input int y, input logic [4:0] fi, input int stall_pct);
    logic acc = 0;
    while (!acc) cycle(1'b1, o, x, y, fi, ($urandom_range(99) >= stall_pct), acc);
  endtask

  initial begin
    logic acc;
    // R12: reset state
    repeat (3) begin
      @(negedge clk);
      n_cmp++;
      if (out_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R12: out_valid actual %0b expected 0", out_valid);
      end
    end
    rst_n = 1'b1;

    // directed corners, no back-pressure
    send(0, 8'h0F, 8'h01, 5'h00, 0);   // R1 half carry
    send(0, 8'h7F, 8'h01, 5'h00, 0);   // R1 overflow
    send(0, 8'hFF, 8'h01, 5'h00, 0);   // R1 carry, zero
    send(1, 8'hFE, 8'h01, 5'h01, 0);   // R1 adc with carry in
    send(2, 8'h10, 8'h01, 5'h00, 0);   // R2 half borrow
    send(2, 8'h00, 8'h01, 5'h00, 0);   // R2 borrow
    send(2, 8'h80, 8'h01, 5'h00, 0);   // R2 overflow
    send(3, 8'h05, 8'h04, 5'h01, 0);   // R3 zero result, Z in clear -> Z stays 0
    send(3, 8'h05, 8'h04, 5'h03, 0);   // R3 zero result, Z in set -> Z 1
    send(5, 8'h05, 8'h03, 5'h03, 0);   // R3 nonzero clears Z, R4 no write
    send(4, 8'h22, 8'h22, 5'h00, 0);   // R4 compare equal
    send(6, 8'hF0, 8'h3C, 5'h1F, 0);   // R5, C/H kept
    send(7, 8'h00, 8'h00, 5'h11, 0);   // R5
    send(8, 8'h80, 8'h01, 5'h08, 0);   // R5 V cleared
    send(9, 8'h55, 8'h00, 5'h10, 0);   // R6
    send(9, 8'hFF, 8'h00, 5'h00, 0);   // R6 zero result
    send(10, 8'h80, 8'h00, 5'h00, 0);  // R7 overflow case
    send(10, 8'h00, 8'h00, 5'h1F, 0);  // R7 zero operand
    send(10, 8'h10, 8'h00, 5'h00, 0);  // R7 low nibble zero
    send(11, 8'h7F, 8'h00, 5'h01, 0);  // R8 inc overflow, C kept
    send(11, 8'hFF, 8'h00, 5'h10, 0);  // R8 wrap to zero
    send(12, 8'h80, 8'h00, 5'h00, 0);  // R8 dec overflow
    send(12, 8'h01, 8'h00, 5'h11, 0);  // R8 dec to zero
    send(13, 8'hA5, 8'h00, 5'h1F, 0);  // R9 clear
    send(14, 8'h12, 8'h00, 5'h0A, 0);  // R9 set-all, flags untouched (R10)
    send(15, 8'h3C, 8'h99, 5'h15, 0);  // R13 reserved

    // random traffic with back-pressure and idle gaps (R11)
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(9) == 0) cycle(1'b0, 0, 0, 0, 5'h00, $urandom_range(1), acc);
      send($urandom_range(15), $urandom_range(255), $urandom_range(255),
           5'($urandom_range(31)), 30);
    end
    // drain
    for (int i = 0; i < 8; i++) cycle(1'b0, 0, 0, 0, 5'h00, 1'b1, acc);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // watchdog
  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL R11: watchdog expired after %0d cycles (expected completion)", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule